// File: doc/BRIEF.md
# Two-Level Interrupt Priority and Vector Unit

This block decides which of eight interrupt requests a small 8-bit core should service next, and gives the core the entry address of that request. Six of the requests arrive as flags that neighbouring logic already produces: two external interrupts, three timers and the serial port. The remaining two are external interrupt lines, the third and the fourth. This block owns the pin sampling, the edge or level detection and the pending flags for those two lines. Software sets a per-source enable and a per-source priority level. A global enable input gates every request.

Each source belongs to a low or a high priority level. Within a level, the winner is the lowest-numbered source in a fixed order. When the core takes a request it pulses `irq_ack`, and the block marks that level as in service. A high-level request can interrupt a low-level service routine. Nothing can interrupt a high-level routine, and a low-level request waits while any routine is in service. The core pulses `reti` when a routine returns. This releases the most recently entered level.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every enable, priority, trigger-type and pending bit reads 0, no request is presented (`irq_valid`=0) and `in_svc`=00.
- R2: Source index i (0 INT0, 1 timer 0, 2 INT1, 3 timer 1, 4 serial, 5 timer 2, 6 INT2, 7 INT3) is presented on `irq_vector` as 03h + 8*i, so the addresses run 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h, 3Bh.
- R3: Among the enabled requests of one level, the lowest source index wins.
- R4: An eligible high-level request wins over any low-level request, whatever their indices.
- R5: A request is considered only if its enable bit is 1 and `glb_en` is 1. Otherwise it never produces `irq_valid`.
- R6: In edge mode (trigger bit = 1), a 1-then-0 sequence on the line, seen on two successive clock samples, sets the pending bit. The bit reads 1 two clocks after the pin falls. A steady low or a rising edge sets nothing.
- R7: In edge mode, the pending bit of line 6 or 7 clears on the clock where the core acknowledges that source.
- R8: In level mode (trigger bit = 0), the pending bit equals the inverted pin two clocks later, and software writes to the pending bit have no effect.
- R9: While the high level is in service, nothing is presented. While only the low level is in service, only high-level requests are presented. An acknowledge sets the in-service bit of the winner's level (`in_svc[1]` high, `in_svc[0]` low).
- R10: A `reti` pulse clears `in_svc[1]` if it is set, and otherwise clears `in_svc[0]`.
- R11: Configuration is written with `cfg_we` and read on `cfg_rdata` for the register chosen by `cfg_sel`. Register 0 holds the enables of sources 0..5 in bits 5:0. Register 1 holds their high-priority bits in bits 5:0. Register 2 holds the control of lines 6 and 7, from bit 7 down to bit 0: line-7 priority, line-7 enable, line-7 pending, line-7 trigger type, line-6 priority, line-6 enable, line-6 pending, line-6 trigger type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Global request gate |
| src_req | input | 6 | Request flags of sources 0..5 |
| int2_n | input | 1 | External line for source 6, active low |
| int3_n | input | 1 | External line for source 7, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select (0, 1, 2) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read view of the selected register |
| irq_ack | input | 1 | Core takes the presented request |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_valid | output | 1 | A request is presented |
| irq_src | output | 3 | Index of the presented source |
| irq_vector | output | 8 | Entry address of the presented source |
| in_svc | output | 2 | In-service bits {high, low} |

## Verification
Errors in the in-service bits show up at once. A stuck high bit silences `irq_valid` on the next cycle. A lost low bit lets a low-level request through while another routine runs. Both appear on `in_svc` one clock after the `ack` or `reti` that caused them. A wrong pending or sampled-pin register shows in `cfg_rdata` bit 1 or bit 5, and in `irq_src`, two clocks after the pin moves. The reference model is compared with every output on every cycle, so each such fault is reported in the first cycle it becomes visible.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

    localparam int NUM_CORE = 6;                 // flag-driven sources
    localparam int NUM_EXT  = 2;                 // pin-driven sources
    localparam int NUM_SRC  = NUM_CORE + NUM_EXT;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int CFG_W    = 8;
    localparam int SEL_W    = 2;
    localparam int VEC_W    = 8;
    localparam int VEC_SHIFT = 3;                // 8-byte spacing of entries
    localparam logic [VEC_W-1:0] VEC_BASE = 8'h03;

    // Field positions inside the line-control register, per line g:
    // trigger at 4g, pending at 4g+1, enable at 4g+2, priority at 4g+3
    localparam int XF_IT  = 0;
    localparam int XF_PND = 1;
    localparam int XF_EN  = 2;
    localparam int XF_PRI = 3;
    localparam int XF_STRIDE = 4;

    localparam logic [SEL_W-1:0] SEL_EN   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_PRI  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_XCTL = 2'd2;

    typedef struct packed {
        logic [NUM_CORE-1:0] en;
        logic [NUM_CORE-1:0] pri;
        logic [NUM_EXT-1:0]  ext_it;
        logic [NUM_EXT-1:0]  ext_en;
        logic [NUM_EXT-1:0]  ext_pri;
        logic                isr_hi;
        logic                isr_lo;
    } arb_state_t;

    function automatic logic [VEC_W-1:0] vec_addr(input logic [SRC_W-1:0] idx);
        return VEC_BASE + (VEC_W'(idx) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/irq_ext_line.sv
`timescale 1ns/1ps
module irq_ext_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic sw_we,
    input  logic sw_val,
    input  logic svc_clr,
    output logic flag,
    output logic pin_s
);

    typedef struct packed {
        logic smp;    // latest pin sample
        logic prv;    // sample one clock older
        logic pnd;    // pending flag
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = pin_n;
        st_d.prv = st_q.smp;
        if (edge_mode) begin
            if (sw_we)
                st_d.pnd = sw_val;
            if (svc_clr)
                st_d.pnd = 1'b0;
            if (st_q.prv && !st_q.smp)
                st_d.pnd = 1'b1;
        end else begin
            st_d.pnd = ~st_q.smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{smp: 1'b1, prv: 1'b1, pnd: 1'b0};
        else
            st_q <= st_d;
    end

    assign flag  = st_q.pnd;
    assign pin_s = st_q.smp;

endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
    parameter  int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      glb_en,
    input  logic [NUM_CORE-1:0]       src_req,
    input  logic                      int2_n,
    input  logic                      int3_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [CFG_W-1:0]          cfg_wdata,
    output logic [CFG_W-1:0]          cfg_rdata,
    input  logic                      irq_ack,
    input  logic                      reti,
    output logic                      irq_valid,
    output logic [SRC_W-1:0]          irq_src,
    output logic [VEC_W-1:0]          irq_vector,
    output logic [1:0]                in_svc
);

    arb_state_t st_d, st_q;

    logic [NUM_EXT-1:0] ext_pin_n;
    logic [NUM_EXT-1:0] ext_flag;
    logic [NUM_EXT-1:0] ext_pin_s;
    logic [NUM_SRC-1:0] req_all;
    logic [NUM_SRC-1:0] pri_all;
    logic [NUM_SRC-1:0] req_hi;
    logic [NUM_SRC-1:0] req_lo;
    logic               hi_found, lo_found;
    logic [SRC_W-1:0]   hi_idx, lo_idx;
    logic               hi_ok, lo_ok;
    logic               win_hi;
    logic [SRC_W-1:0]   win_idx;
    logic               take;
    logic               xwr;
    logic [CFG_W-1:0]   xctl_view;

    assign ext_pin_n = {int3_n, int2_n};
    assign xwr       = cfg_we && (cfg_sel == SEL_XCTL);

    // Pin-driven lines: sampling, detection and pending flag
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_line
        localparam logic [SRC_W-1:0] MY_IDX = SRC_W'(NUM_CORE + g);
        irq_ext_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[g]),
            .edge_mode (st_q.ext_it[g]),
            .sw_we     (xwr),
            .sw_val    (cfg_wdata[XF_STRIDE*g + XF_PND]),
            .svc_clr   (take && (win_idx == MY_IDX)),
            .flag      (ext_flag[g]),
            .pin_s     (ext_pin_s[g])
        );
        assign xctl_view[XF_STRIDE*g + XF_IT]  = st_q.ext_it[g];
        assign xctl_view[XF_STRIDE*g + XF_PND] = ext_flag[g];
        assign xctl_view[XF_STRIDE*g + XF_EN]  = st_q.ext_en[g];
        assign xctl_view[XF_STRIDE*g + XF_PRI] = st_q.ext_pri[g];
    end

    // Request and level vectors in polling order
    assign req_all = glb_en ? {ext_flag & st_q.ext_en, src_req & st_q.en} : '0;
    assign pri_all = {st_q.ext_pri, st_q.pri};
    assign req_hi  = req_all & pri_all;
    assign req_lo  = req_all & ~pri_all;

    irq_pick #(.N(NUM_SRC)) u_pick_hi (
        .req   (req_hi),
        .found (hi_found),
        .idx   (hi_idx)
    );

    irq_pick #(.N(NUM_SRC)) u_pick_lo (
        .req   (req_lo),
        .found (lo_found),
        .idx   (lo_idx)
    );

    // Preemption gate
    assign hi_ok   = hi_found && !st_q.isr_hi;
    assign lo_ok   = lo_found && !st_q.isr_hi && !st_q.isr_lo;
    assign win_hi  = hi_ok;
    assign win_idx = hi_ok ? hi_idx : lo_idx;
    assign take    = irq_valid && irq_ack;

    assign irq_valid  = hi_ok || lo_ok;
    assign irq_src    = win_idx;
    assign irq_vector = vec_addr(win_idx);
    assign in_svc     = {st_q.isr_hi, st_q.isr_lo};

    always_comb begin
        unique case (cfg_sel)
            SEL_EN:   cfg_rdata = CFG_W'(st_q.en);
            SEL_PRI:  cfg_rdata = CFG_W'(st_q.pri);
            SEL_XCTL: cfg_rdata = xctl_view;
            default:  cfg_rdata = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_EN:  st_d.en  = cfg_wdata[NUM_CORE-1:0];
                SEL_PRI: st_d.pri = cfg_wdata[NUM_CORE-1:0];
                SEL_XCTL: begin
                    for (int g = 0; g < NUM_EXT; g++) begin
                        st_d.ext_it[g]  = cfg_wdata[XF_STRIDE*g + XF_IT];
                        st_d.ext_en[g]  = cfg_wdata[XF_STRIDE*g + XF_EN];
                        st_d.ext_pri[g] = cfg_wdata[XF_STRIDE*g + XF_PRI];
                    end
                end
                default: ;
            endcase
        end
        if (reti) begin
            if (st_q.isr_hi)
                st_d.isr_hi = 1'b0;
            else
                st_d.isr_lo = 1'b0;
        end
        if (take) begin
            if (win_hi)
                st_d.isr_hi = 1'b1;
            else
                st_d.isr_lo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_en,
    input logic       irq_valid,
    input logic [2:0] irq_src,
    input logic [7:0] irq_vector,
    input logic       irq_ack,
    input logic       reti,
    input logic [1:0] in_svc,
    input logic       win_hi,
    input logic [7:0] req_all,
    input logic [1:0] ext_it,
    input logic [1:0] ext_pin_s,
    input logic [1:0] ext_flag
);

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq_valid);                                        // R5

    AST_VEC_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_vector == {irq_src, 3'b011});                 // R2

    AST_WIN_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> req_all[irq_src]);                                // R3

    AST_HI_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[1] |-> !irq_valid);                                      // R9

    AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc[0] && irq_valid) |-> win_hi);                           // R9

    AST_TAKE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && win_hi) |=> in_svc[1]);                // R9

    AST_RETI_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_svc[1] && !(irq_valid && irq_ack)) |=> !in_svc[1]); // R10

    for (genvar g = 0; g < 2; g++) begin : g_line_chk
        AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_it[g] && $past(ext_pin_s[g]) && !ext_pin_s[g]) |=> ext_flag[g]); // R6

        AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            !ext_it[g] |=> ext_flag[g] == !$past(ext_pin_s[g]));        // R8
    end

endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_en     (glb_en),
    .irq_valid  (irq_valid),
    .irq_src    (irq_src),
    .irq_vector (irq_vector),
    .irq_ack    (irq_ack),
    .reti       (reti),
    .in_svc     (in_svc),
    .win_hi     (win_hi),
    .req_all    (req_all),
    .ext_it     (st_q.ext_it),
    .ext_pin_s  (ext_pin_s),
    .ext_flag   (ext_flag)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_en = 1'b0;
    logic [5:0] src_req = '0;
    logic       int2_n = 1'b1;
    logic       int3_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       irq_ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq_valid;
    logic [2:0] irq_src;
    logic [7:0] irq_vector;
    logic [1:0] in_svc;

    always #10 clk = ~clk;   // 50 MHz

    irq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_req(src_req),
        .int2_n(int2_n), .int3_n(int3_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_ack(irq_ack),
        .reti(reti), .irq_valid(irq_valid), .irq_src(irq_src),
        .irq_vector(irq_vector), .in_svc(in_svc)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // ---------------- behavioural reference model ----------------
    bit [5:0] m_en, m_pri;
    bit [1:0] m_it, m_ex, m_px, m_flag, m_smp, m_prv;
    bit       m_ih, m_il;
    bit       e_valid, e_hi;
    int       e_idx;

    function void calc();
        int hi, lo;
        bit r, p;
        hi = -1; lo = -1;
        for (int i = 7; i >= 0; i--) begin
            if (i < 6) begin r = src_req[i] & m_en[i]; p = m_pri[i]; end
            else       begin r = m_flag[i-6] & m_ex[i-6]; p = m_px[i-6]; end
            r = r & glb_en;
            if (r && p)  hi = i;
            if (r && !p) lo = i;
        end
        e_valid = 0; e_hi = 0; e_idx = 0;
        if (hi >= 0 && !m_ih) begin e_valid = 1; e_hi = 1; e_idx = hi; end
        else if (lo >= 0 && !m_ih && !m_il) begin e_valid = 1; e_idx = lo; end
    endfunction

    function int exp_rdata();
        case (cfg_sel)
            2'd0: return int'(m_en);
            2'd1: return int'(m_pri);
            2'd2: return int'({m_px[1], m_ex[1], m_flag[1], m_it[1],
                               m_px[0], m_ex[0], m_flag[0], m_it[0]});
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_pri = 0; m_it = 0; m_ex = 0; m_px = 0; m_flag = 0;
            m_smp = 2'b11; m_prv = 2'b11; m_ih = 0; m_il = 0;
        end else begin
            bit       take;
            bit [1:0] nflag;
            calc();
            take = e_valid && irq_ack;
            for (int g = 0; g < 2; g++) begin
                if (m_it[g]) begin
                    nflag[g] = m_flag[g];
                    if (cfg_we && cfg_sel == 2) nflag[g] = cfg_wdata[4*g+1];
                    if (take && e_idx == 6 + g) nflag[g] = 0;
                    if (m_prv[g] && !m_smp[g]) nflag[g] = 1;
                end else begin
                    nflag[g] = !m_smp[g];
                end
            end
            m_flag = nflag;
            m_prv  = m_smp;
            m_smp  = {int3_n, int2_n};
            if (cfg_we) begin
                if (cfg_sel == 0) m_en  = cfg_wdata[5:0];
                if (cfg_sel == 1) m_pri = cfg_wdata[5:0];
                if (cfg_sel == 2) begin
                    for (int g = 0; g < 2; g++) begin
                        m_it[g] = cfg_wdata[4*g];
                        m_ex[g] = cfg_wdata[4*g+2];
                        m_px[g] = cfg_wdata[4*g+3];
                    end
                end
            end
            if (reti) begin
                if (m_ih) m_ih = 0; else m_il = 0;
            end
            if (take) begin
                if (e_hi) m_ih = 1; else m_il = 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            calc();
            chk({cur_req, " model valid"}, int'(irq_valid), int'(e_valid));
            if (e_valid) begin
                chk({cur_req, " model src"}, int'(irq_src), e_idx);
                chk({cur_req, " model vector"}, int'(irq_vector), 3 + 8 * e_idx);
            end
            chk({cur_req, " model in_svc"}, int'(in_svc), int'({m_ih, m_il}));
            chk({cur_req, " model rdata"}, int'(cfg_rdata), exp_rdata());
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wcfg(input logic [1:0] sel, input logic [7:0] data);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        tick(1);
        cfg_we = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1; tick(1); irq_ack = 0; #1;
    endtask

    task automatic pulse_reti();
        reti = 1; tick(1); reti = 0; #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        chk("R1 valid in reset", int'(irq_valid), 0);
        chk("R1 in_svc in reset", int'(in_svc), 0);
        for (int s = 0; s < 3; s++) begin
            cfg_sel = 2'(s); #1;
            chk("R1 register reads zero", int'(cfg_rdata), 0);
        end
        rst_n = 1;
        tick(2);
        chk("R1 idle after release", int'(irq_valid), 0);

        // R3 / R2: polling order and vectors
        cur_req = "R3";
        wcfg(2'd0, 8'h3F);
        glb_en = 1; src_req = 6'h3F; #1;
        chk("R3 lowest index wins", int'(irq_src), 0);
        chk("R2 vector of INT0", int'(irq_vector), 8'h03);
        src_req = 6'b001100; #1;
        chk("R3 index 2 beats 3", int'(irq_src), 2);
        cur_req = "R2";
        for (int i = 0; i < 6; i++) begin
            src_req = 6'(1 << i); #1;
            chk("R2 single source vector", int'(irq_vector), 3 + 8 * i);
        end
        tick(1);

        // R4: high level over low level
        cur_req = "R4";
        wcfg(2'd1, 8'h20);
        src_req = 6'h21; #1;
        chk("R4 high priority timer 2 wins", int'(irq_src), 5);
        chk("R4 vector 2Bh", int'(irq_vector), 8'h2B);
        wcfg(2'd1, 8'h00);

        // R5: enables
        cur_req = "R5";
        glb_en = 0; #1;
        chk("R5 global gate", int'(irq_valid), 0);
        glb_en = 1;
        wcfg(2'd0, 8'h3E);
        src_req = 6'h01; #1;
        chk("R5 disabled source ignored", int'(irq_valid), 0);
        wcfg(2'd0, 8'h3F);
        src_req = 6'h00;
        tick(1);

        // R11 / R6 / R7: line 6 in edge mode
        cur_req = "R11";
        wcfg(2'd2, 8'h05);
        cfg_sel = 2'd2; #1;
        chk("R11 line control readback", int'(cfg_rdata), 8'h05);
        cur_req = "R6";
        int2_n = 0;
        tick(1);
        chk("R6 not pending one clock after fall", int'(cfg_rdata), 8'h05);
        tick(1);
        chk("R6 pending two clocks after fall", int'(cfg_rdata), 8'h07);
        chk("R6 line 6 presented", int'(irq_src), 6);
        chk("R2 vector 33h", int'(irq_vector), 8'h33);
        cur_req = "R7";
        pulse_ack();
        chk("R7 pending cleared on service", int'(cfg_rdata), 8'h05);
        chk("R9 low level in service", int'(in_svc), 1);
        cur_req = "R6";
        tick(2);
        chk("R6 steady low sets nothing", int'(cfg_rdata), 8'h05);
        int2_n = 1;
        tick(3);
        chk("R6 rising edge sets nothing", int'(cfg_rdata), 8'h05);
        cur_req = "R10";
        pulse_reti();
        chk("R10 reti clears low level", int'(in_svc), 0);

        // R8: line 7 in level mode
        cur_req = "R8";
        wcfg(2'd2, 8'h40);
        int3_n = 0;
        tick(1);
        chk("R8 level flag not yet", int'(cfg_rdata), 8'h40);
        tick(1);
        chk("R8 level flag follows pin", int'(cfg_rdata), 8'h60);
        chk("R2 vector 3Bh", int'(irq_vector), 8'h3B);
        int3_n = 1;
        tick(2);
        chk("R8 level flag drops with pin", int'(cfg_rdata), 8'h40);
        wcfg(2'd2, 8'h60);
        #1;
        chk("R8 software write ignored in level mode", int'(cfg_rdata), 8'h40);
        chk("R8 nothing presented", int'(irq_valid), 0);
        wcfg(2'd2, 8'h00);

        // R9 / R10: preemption
        cur_req = "R9";
        src_req = 6'h01; #1;
        pulse_ack();
        chk("R9 low in service", int'(in_svc), 1);
        chk("R9 low blocked by low", int'(irq_valid), 0);
        wcfg(2'd1, 8'h02);
        src_req = 6'b000011; #1;
        chk("R9 high preempts low", int'(irq_valid), 1);
        chk("R9 preempting source", int'(irq_src), 1);
        pulse_ack();
        chk("R9 both levels in service", int'(in_svc), 3);
        wcfg(2'd1, 8'h0A);
        src_req = 6'b001011; #1;
        chk("R9 high blocked by high", int'(irq_valid), 0);
        cur_req = "R10";
        pulse_reti();
        chk("R10 first reti clears high", int'(in_svc), 1);
        chk("R10 high eligible again", int'(irq_src), 1);
        pulse_reti();
        chk("R10 second reti clears low", int'(in_svc), 0);
        cur_req = "R4";
        chk("R4 high index 1 over low index 0", int'(irq_src), 1);
        cur_req = "R10";
        src_req = 6'h00;
        pulse_reti();
        chk("R10 spare reti harmless", int'(in_svc), 0);
        tick(2);

        finish_run();
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL R1: watchdog expired, got running expected done");
        finish_run();
    end

endmodule